// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each data beat of a synchronous DRAM read or write burst. A column command supplies a start column, an encoded burst length and an ordering choice. The block then steps through the columns of the burst, one beat per clock. The length and ordering arrive already decoded from the mode settings, so the block only turns them into an address sequence. It does not move data and does not access the array.

Fixed bursts of 2, 4 or 8 beats stay inside an aligned window. The offset inside that window either counts up and wraps (sequential) or is formed as the start offset XOR the beat index (interleave). The column bits above the window do not change. Full-page mode walks all 256 columns of the row in sequential order and wraps for as long as it runs. Only a stop or a new start ends it.

The controller has three states. IDLE has no burst in flight. FIXED is running a 1/2/4/8-beat burst. PAGE is running a full-page burst. The transitions are:
- IDLE to FIXED or PAGE, on start.
- FIXED to FIXED with the beat count reset, on start.
- FIXED or PAGE to PAGE with the count reset, on start with the full-page code.
- FIXED to IDLE, after the final beat.
- FIXED or PAGE to IDLE, on stop.
- PAGE to PAGE, on every other cycle, with the count wrapping.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `valid_o` and `last_o` are low.
- R2: A start sampled at a rising edge makes beat 0 appear on the next cycle with `col_o` equal to the start column. One further beat follows on each later cycle, and `valid_o` stays high while the burst runs.
- R3: The `blen_i` encoding is 0 for 1 beat, 1 for 2 beats, 2 for 4 beats, 3 for 8 beats and 7 for full page. Codes 4 to 6 behave as a single beat.
- R4: When `burst_type_i` is 0 (sequential), the offset inside the window counts up from the start offset and wraps. For example, length 4 starting at offset 1 gives offsets 1,2,3,0.
- R5: When `burst_type_i` is 1 (interleave), the offset of beat i is the start offset XOR i. For example, length 8 starting at offset 5 gives offsets 5,4,7,6,1,0,3,2.
- R6: The column bits above the burst window hold the start column's value for the whole burst.
- R7: In fixed-length bursts, `last_o` is high on the final beat only. `valid_o` drops on the cycle after the final beat unless a new start was sampled.
- R8: Full-page mode steps through all 256 columns in sequential order and wraps from 255 to 0 without end. It ignores `burst_type_i` and never raises `last_o`.
- R9: A stop sampled at an edge with no start makes `valid_o` low on the next cycle. A stop while idle has no effect.
- R10: A start sampled during a burst makes beat 0 of the new burst appear on the next cycle, with no idle cycle. When start and stop are sampled together, the start wins.
- R11: A burst length of 1 gives exactly one beat at the start column, with `last_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Column command strobe, starts a burst |
| stop_i | input | 1 | Burst stop strobe |
| start_col_i | input | 8 | Start column of the burst |
| blen_i | input | 3 | Encoded burst length (see R3) |
| burst_type_i | input | 1 | 0 sequential, 1 interleave |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is in progress |
| last_o | output | 1 | Current beat is the last of a fixed burst |

## Verification
The assertions assume that the start column and length are only meaningful in the cycle where `start_i` is high. They also assume that `blen_i` value 7 alone selects full-page mode, so the checker keeps its own record of which mode the running burst was started in. The stimulus changes every input only on the falling clock edge and holds the column, length and type steady around each start. It issues overlapping strobes deliberately, both a start during a running burst and a start together with a stop, so the precedence rules are exercised on purpose rather than by accident.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } bcg_state_e;

    localparam int          BCG_COL_W   = 8;
    localparam int          BCG_CODE_W  = 3;
    localparam int          BCG_MAX_LOG = 3;
    localparam logic [2:0]  BCG_PAGE_CODE = 3'd7;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode #(
    parameter int         COL_W     = 8,
    parameter int         CODE_W    = 3,
    parameter int         MAX_LOG   = 3,
    parameter logic [CODE_W-1:0] PAGE_CODE = '1
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [COL_W-1:0]  mask_o,
    output logic              page_o
);
    logic              fixed_ok;
    logic [COL_W-1:0]  win_mask;

    assign page_o   = (code_i == PAGE_CODE);
    assign fixed_ok = (int'(code_i) <= MAX_LOG);

    // one mask bit per column bit: set when the bit lies inside the window
    for (genvar gi = 0; gi < COL_W; gi++) begin : g_mask
        assign win_mask[gi] = fixed_ok && (int'(code_i) > gi);
    end

    assign mask_o = page_o ? {COL_W{1'b1}} : win_mask;
endmodule

// File: rtl/bcg_seq_fsm.sv
module bcg_seq_fsm
    import bcg_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [COL_W-1:0]  mask_i,
    input  logic              page_i,
    input  logic              itl_i,
    output bcg_state_e        state_o,
    output logic [COL_W-1:0]  base_o,
    output logic [COL_W-1:0]  cnt_o,
    output logic [COL_W-1:0]  mask_o,
    output logic              itl_o
);
    bcg_state_e        state_q, state_d;
    logic [COL_W-1:0]  cnt_q, cnt_d;
    logic [COL_W-1:0]  base_q, mask_q;
    logic              itl_q;
    logic              load;

    // next-state process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load    = 1'b0;
        if (start_i) begin
            load    = 1'b1;
            cnt_d   = '0;
            state_d = page_i ? ST_PAGE : ST_FIXED;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;
                end
                ST_FIXED: begin
                    if (cnt_q == mask_q) state_d = ST_IDLE;
                    else                 cnt_d   = cnt_q + 1'b1;
                end
                ST_PAGE: begin
                    cnt_d = cnt_q + 1'b1;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            base_q  <= '0;
            mask_q  <= '0;
            itl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (load) begin
                base_q <= start_col_i;
                mask_q <= mask_i;
                itl_q  <= itl_i & ~page_i;
            end
        end
    end

    assign state_o = state_q;
    assign base_o  = base_q;
    assign cnt_o   = cnt_q;
    assign mask_o  = mask_q;
    assign itl_o   = itl_q;
endmodule

// File: rtl/bcg_col_map.sv
module bcg_col_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             itl_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] off;

    always_comb begin
        off   = itl_i ? (base_i ^ cnt_i) : (base_i + cnt_i);
        col_o = (base_i & ~mask_i) | (off & mask_i);
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import bcg_pkg::*;
#(
    parameter int COL_W   = BCG_COL_W,
    parameter int CODE_W  = BCG_CODE_W,
    parameter int MAX_LOG = BCG_MAX_LOG
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [CODE_W-1:0] blen_i,
    input  logic              burst_type_i,
    output logic [COL_W-1:0]  col_o,
    output logic              valid_o,
    output logic              last_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_page;
    bcg_state_e       state;
    logic [COL_W-1:0] base, cnt, mask_q, col;
    logic             itl_q;

    bcg_len_decode #(
        .COL_W     (COL_W),
        .CODE_W    (CODE_W),
        .MAX_LOG   (MAX_LOG),
        .PAGE_CODE ({CODE_W{1'b1}})
    ) u_dec (
        .code_i (blen_i),
        .mask_o (dec_mask),
        .page_o (dec_page)
    );

    bcg_seq_fsm #(.COL_W(COL_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .stop_i      (stop_i),
        .start_col_i (start_col_i),
        .mask_i      (dec_mask),
        .page_i      (dec_page),
        .itl_i       (burst_type_i),
        .state_o     (state),
        .base_o      (base),
        .cnt_o       (cnt),
        .mask_o      (mask_q),
        .itl_o       (itl_q)
    );

    bcg_col_map #(.COL_W(COL_W)) u_map (
        .base_i (base),
        .cnt_i  (cnt),
        .mask_i (mask_q),
        .itl_i  (itl_q),
        .col_o  (col)
    );

    // output process
    always_comb begin
        col_o   = col;
        valid_o = (state != ST_IDLE);
        last_o  = (state == ST_FIXED) && (cnt == mask_q);
    end
endmodule

// File: rtl/bcg_chk.sv
module bcg_chk #(
    parameter int COL_W   = 8,
    parameter int CODE_W  = 3,
    parameter int MAX_LOG = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              stop_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic [CODE_W-1:0] blen_i,
    input logic [COL_W-1:0]  col_o,
    input logic              valid_o,
    input logic              last_o
);
    logic page_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       page_q <= 1'b0;
        else if (start_i) page_q <= (blen_i == {CODE_W{1'b1}});
    end

    // R2
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i)));

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    // R7
    end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !valid_o);

    // R9
    stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o);

    // R8
    page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && page_q) |-> !last_o);

    // R8
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && page_q && $past(valid_o) && !$past(start_i))
            |-> (col_o == $past(col_o) + 1'b1));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !page_q && $past(valid_o) && !$past(start_i))
            |-> (col_o[COL_W-1:MAX_LOG] == $past(col_o[COL_W-1:MAX_LOG])));
endmodule

bind burst_col_gen bcg_chk #(
    .COL_W   (COL_W),
    .CODE_W  (CODE_W),
    .MAX_LOG (MAX_LOG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .blen_i      (blen_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] blen_i = '0;
    logic       burst_type_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o;
    logic       last_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .start_col_i  (start_col_i),
        .blen_i       (blen_i),
        .burst_type_i (burst_type_i),
        .col_o        (col_o),
        .valid_o      (valid_o),
        .last_o       (last_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_col(input logic [7:0] base, input int lg,
                                           input bit itl, input int i);
        logic [7:0] m, off;
        m   = 8'((1 << lg) - 1);
        off = itl ? (base ^ 8'(i)) : (base + 8'(i));
        return (base & ~m) | (off & m);
    endfunction

    // called at a falling edge; returns at the falling edge showing beat 0
    task automatic launch(input logic [2:0] code, input bit itl, input logic [7:0] col,
                          input bit with_stop);
        start_i = 1'b1; stop_i = with_stop;
        blen_i = code; burst_type_i = itl; start_col_i = col;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0;
    endtask

    // checks n beats from the current falling edge; last expected on beat n-1 if fixed
    task automatic beats(input string tag, input logic [7:0] base, input int lg,
                         input bit itl, input int n, input bit fixed_len);
        for (int i = 0; i < n; i++) begin
            chk(valid_o === 1'b1, {tag, " valid"}, valid_o, 1);
            chk(col_o === exp_col(base, lg, itl, i), {tag, " col"}, col_o, exp_col(base, lg, itl, i));
            chk(last_o === (fixed_len && i == n - 1), {tag, " last"}, last_o, (fixed_len && i == n - 1));
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(valid_o === 1'b0 && last_o === 1'b0, "R1 in reset", {valid_o, last_o}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(valid_o === 1'b0 && last_o === 1'b0, "R1 after reset", {valid_o, last_o}, 0);
    endtask

    task automatic t_seq4();
        launch(3'd2, 1'b0, 8'h41, 1'b0);
        beats("R4 R6 R7 seq len4 off1", 8'h41, 2, 1'b0, 4, 1'b1);
        chk(valid_o === 1'b0, "R7 idle after last", valid_o, 0);
    endtask

    task automatic t_itl8();
        launch(3'd3, 1'b1, 8'h25, 1'b0);
        beats("R5 R6 itl len8 off5", 8'h25, 3, 1'b1, 8, 1'b1);
        chk(valid_o === 1'b0, "R7 idle after itl8", valid_o, 0);
    endtask

    task automatic t_seq2_seq8();
        launch(3'd1, 1'b0, 8'h9B, 1'b0);
        beats("R3 R4 seq len2", 8'h9B, 1, 1'b0, 2, 1'b1);
        launch(3'd3, 1'b0, 8'hC6, 1'b0);
        beats("R4 seq len8 off6", 8'hC6, 3, 1'b0, 8, 1'b1);
        launch(3'd2, 1'b1, 8'h72, 1'b0);
        beats("R5 itl len4 off2", 8'h72, 2, 1'b1, 4, 1'b1);
        chk(valid_o === 1'b0, "R2 idle after bursts", valid_o, 0);
    endtask

    task automatic t_len1();
        launch(3'd0, 1'b1, 8'hE3, 1'b0);
        beats("R11 len1", 8'hE3, 0, 1'b0, 1, 1'b1);
        chk(valid_o === 1'b0, "R11 one beat only", valid_o, 0);
        launch(3'd5, 1'b0, 8'h17, 1'b0);
        beats("R3 reserved code as len1", 8'h17, 0, 1'b0, 1, 1'b1);
        chk(valid_o === 1'b0, "R3 reserved one beat", valid_o, 0);
    endtask

    task automatic t_page();
        launch(3'd7, 1'b1, 8'hFE, 1'b0);
        beats("R8 full page wrap", 8'hFE, 8, 1'b0, 300, 1'b0);
        chk(valid_o === 1'b1, "R8 still running", valid_o, 1);
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk(valid_o === 1'b0, "R9 stop ends page", valid_o, 0);
    endtask

    task automatic t_stop_fixed();
        launch(3'd3, 1'b0, 8'h10, 1'b0);
        beats("R9 pre-stop", 8'h10, 3, 1'b0, 3, 1'b0);
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk(valid_o === 1'b0 && last_o === 1'b0, "R9 stop mid burst", {valid_o, last_o}, 0);
        stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        chk(valid_o === 1'b0, "R9 stop while idle", valid_o, 0);
        launch(3'd1, 1'b0, 8'h20, 1'b0);
        beats("R9 normal after idle stop", 8'h20, 1, 1'b0, 2, 1'b1);
    endtask

    task automatic t_restart();
        launch(3'd3, 1'b1, 8'h33, 1'b0);
        beats("R10 first burst", 8'h33, 3, 1'b1, 2, 1'b0);
        launch(3'd2, 1'b0, 8'h5E, 1'b0);
        beats("R10 restart no bubble", 8'h5E, 2, 1'b0, 4, 1'b1);
        launch(3'd3, 1'b0, 8'h80, 1'b0);
        beats("R10 before combined", 8'h80, 3, 1'b0, 1, 1'b0);
        launch(3'd1, 1'b1, 8'hA5, 1'b1);
        beats("R10 start beats stop", 8'hA5, 1, 1'b1, 2, 1'b1);
        chk(valid_o === 1'b0, "R10 idle after", valid_o, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_seq4();
        t_itl8();
        t_seq2_seq8();
        t_len1();
        t_page();
        t_stop_fixed();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule